// File: doc/BRIEF.md
# Processor power-on reset sequencer

This block brings a multicore processor out of power-on reset once the board supplies are up. It watches one power-good line per supply rail and the processor's reset-status output, both through two-flop synchronizers. It counts a stabilization delay in system-clock cycles and later intervals in reference-clock rising edges. It then releases three active-low resets, always in the same order: warm reset first, then power-on reset, then full reset. Any rail that drops at any point pulls all three resets low together and sends the sequence back to waiting for the supplies.

The block also drives the boot-strap pins: an endianness bit, a 13-bit boot-mode field, a 2-bit PCIe mode code, a PCIe enable bit and a packet-coprocessor clock-source select. The strap drivers stay disabled and low until the I/O rail is good. While the supplies settle, the strap drivers follow the strap inputs. They freeze when warm reset is released and are held across the full-reset rising edge, where the processor samples them. After a hold window they are released.

Once the straps are released, the sequencer waits for the processor's reset-status output to go high and then reports done. If reset-status does not go high within a bounded number of reference edges, the sequencer sets a sticky timeout flag, returns all resets low and, when restart is enabled, runs the sequence again. The timeout flag clears when a later run completes.

Top module: `por_sequencer`

## Requirements
- R1: After a synchronous reset, and whenever any power-good input is low, warm, power-on and full reset are all low, and done is low.
- R2: Warm reset rises no sooner than STAB_CYC system-clock cycles after the last rail reports good, and no later than STAB_CYC+6 cycles after it.
- R3: Power-on reset rises only while warm reset is high. Between the two rising edges lie REF_INIT to REF_INIT+2 reference-clock rising edges.
- R4: Full reset rises only while power-on reset is high. Between the two rising edges lie at least max(FULL_DLY, STRAP_SETUP) reference edges, and at most that number plus 2.
- R5: At the full-reset rising edge, the strap outputs are enabled and equal the strap inputs as they stood when warm reset rose. The PCIe mode code passes through unchanged (0 endpoint, 1 legacy endpoint, 2 root complex). Input changes after warm reset rises have no effect on the outputs, which have been steady for at least STRAP_SETUP reference edges.
- R6: After the full-reset rising edge, the strap outputs stay unchanged for STRAP_HOLD to STRAP_HOLD+2 reference edges. After that window, the output enable and all strap values are 0.
- R7: While the I/O rail (index IO_RAIL) is not good, the strap output enable and all strap values are 0. Once it is good and before warm reset rises, the output enable is 1 and the values follow the inputs.
- R8: When reset-status rises after the strap release, done rises 2 to 5 system-clock cycles later.
- R9: If reset-status stays low for TMO_TICKS reference edges after the strap release, timeout rises and all resets go low in the same cycle. The sequence then restarts, and warm reset rises again after STAB_CYC to STAB_CYC+6 cycles. Timeout clears when a run completes.
- R10: A power-good drop at any stage forces all three resets and done low within 5 system-clock cycles.
- R11: A reset-status that is already high before the strap release has no effect until then. Done rises 1 to 3 cycles after the strap enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Processor reference clock, sampled and edge-counted |
| rail_good | input | N_RAILS | Power-good per supply rail |
| stat_in | input | 1 | Processor reset-status output |
| strap_endian_in | input | 1 | Endianness strap value to present |
| strap_boot_in | input | 13 | Boot-mode strap value to present |
| strap_pcie_mode_in | input | 2 | PCIe mode code to present |
| strap_pcie_en_in | input | 1 | PCIe enable strap to present |
| strap_pa_sel_in | input | 1 | Coprocessor clock-source select to present |
| warm_rst_n | output | 1 | Warm reset, active low |
| por_rst_n | output | 1 | Power-on reset, active low |
| full_rst_n | output | 1 | Full reset, active low |
| strap_oe | output | 1 | Strap pin output enable |
| strap_endian | output | 1 | Driven endianness strap |
| strap_boot | output | 13 | Driven boot-mode strap |
| strap_pcie_mode | output | 2 | Driven PCIe mode code |
| strap_pcie_en | output | 1 | Driven PCIe enable strap |
| strap_pa_sel | output | 1 | Driven coprocessor clock-source select |
| seq_done | output | 1 | Processor reported out of reset |
| seq_timeout | output | 1 | Sticky: reset-status wait expired |

## Verification
The assertions assume that the reference clock is much slower than the system clock, so that every reference edge appears as exactly one tick after synchronization. They also assume that power-good and reset-status inputs hold each level for at least two system cycles. The bench keeps the reference period at six system cycles and the rails and reset-status changes many cycles apart. It drives inputs just after a system edge, away from the sampling point. Random strap values, rail orders and reset-status delays stay within the timeout window except in the one case that tests the timeout on purpose.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  localparam int BOOT_W = 13;

  typedef enum logic [1:0] {
    PCIE_EP        = 2'd0,
    PCIE_LEGACY_EP = 2'd1,
    PCIE_RC        = 2'd2,
    PCIE_RSVD      = 2'd3
  } pcie_mode_e;

  typedef struct packed {
    logic              endian;
    logic [BOOT_W-1:0] boot;
    pcie_mode_e        pcie_mode;
    logic              pcie_en;
    logic              pa_sel;
  } strap_t;

  typedef enum logic [2:0] {
    ST_SUPPLY,
    ST_STAB,
    ST_REFRUN,
    ST_POR,
    ST_HOLD,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/por_ref_tick.sv
module por_ref_tick (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic tick
);

  logic ref_s;
  logic ref_prev;

  por_sync #(.W(1)) u_ref_sync (
    .clk (clk),
    .rst (rst),
    .d   (ref_in),
    .q   (ref_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ref_prev <= 1'b0;
    else     ref_prev <= ref_s;
  end

  assign tick = ref_s & ~ref_prev;

endmodule

// File: rtl/por_strap_drv.sv
module por_strap_drv
  import por_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   io_ok,
  input  logic   track,
  input  logic   drive,
  input  strap_t strap_in,
  output strap_t strap_q,
  output logic   oe_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= '0;
      oe_q    <= 1'b0;
    end else if (!io_ok) begin
      strap_q <= '0;
      oe_q    <= 1'b0;
    end else if (track) begin
      strap_q <= strap_in;
      oe_q    <= 1'b1;
    end else if (drive) begin
      oe_q    <= 1'b1;
    end else begin
      strap_q <= '0;
      oe_q    <= 1'b0;
    end
  end

  AST_STRAP_IO_GATE: assert property (@(posedge clk) disable iff (rst)
    !io_ok |=> (!oe_q && strap_q == '0)); // R7

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (io_ok && drive && !track) |=> $stable(strap_q)); // R5

endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int STAB_CYC     = 5000,
  parameter int REF_INIT     = 500,
  parameter int FULL_DLY     = 24,
  parameter int STRAP_SETUP  = 12,
  parameter int STRAP_HOLD   = 12,
  parameter int TMO_TICKS    = 60000,
  parameter bit AUTO_RESTART = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pg_ok_all,
  input  logic ref_tick,
  input  logic stat_ok,
  output logic warm_n,
  output logic por_n,
  output logic full_n,
  output logic done,
  output logic timeout,
  output logic strap_track,
  output logic strap_drive
);

  localparam int POR_TICKS = max2(FULL_DLY, STRAP_SETUP);
  localparam int CNT_MAX   = max2(max2(STAB_CYC, REF_INIT),
                                  max2(max2(POR_TICKS, STRAP_HOLD), TMO_TICKS)) + 1;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_CYC - 1);
  localparam logic [CNT_W-1:0] REF_LAST  = CNT_W'(REF_INIT);
  localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_TICKS);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(STRAP_HOLD);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_TICKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             counting;

  always_comb begin
    state_d = state_q;
    if (!pg_ok_all) begin
      state_d = ST_SUPPLY;
    end else begin
      case (state_q)
        ST_SUPPLY: state_d = ST_STAB;
        ST_STAB:   if (cnt == STAB_LAST) state_d = ST_REFRUN;
        ST_REFRUN: if (ref_tick && cnt == REF_LAST) state_d = ST_POR;
        ST_POR:    if (ref_tick && cnt == POR_LAST) state_d = ST_HOLD;
        ST_HOLD:   if (ref_tick && cnt == HOLD_LAST) state_d = ST_WAIT;
        ST_WAIT: begin
          if (stat_ok)                          state_d = ST_DONE;
          else if (ref_tick && cnt == TMO_LAST) state_d = ST_FAIL;
        end
        ST_DONE:   state_d = ST_DONE;
        ST_FAIL:   state_d = AUTO_RESTART ? ST_SUPPLY : ST_FAIL;
        default:   state_d = ST_SUPPLY;
      endcase
    end
  end

  assign counting = (state_q == ST_STAB) ||
                    (ref_tick && (state_q inside {ST_REFRUN, ST_POR, ST_HOLD, ST_WAIT}));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SUPPLY;
      cnt     <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt <= '0;
      else if (counting)      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_n  <= 1'b0;
      por_n   <= 1'b0;
      full_n  <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      warm_n <= state_d inside {ST_REFRUN, ST_POR, ST_HOLD, ST_WAIT, ST_DONE};
      por_n  <= state_d inside {ST_POR, ST_HOLD, ST_WAIT, ST_DONE};
      full_n <= state_d inside {ST_HOLD, ST_WAIT, ST_DONE};
      done   <= (state_d == ST_DONE);
      if (state_d == ST_DONE)      timeout <= 1'b0;
      else if (state_d == ST_FAIL) timeout <= 1'b1;
    end
  end

  assign strap_track = state_d inside {ST_SUPPLY, ST_STAB};
  assign strap_drive = state_d inside {ST_REFRUN, ST_POR, ST_HOLD};

  AST_POR_AFTER_WARM: assert property (@(posedge clk) disable iff (rst)
    por_n |-> warm_n); // R3

  AST_FULL_AFTER_POR: assert property (@(posedge clk) disable iff (rst)
    full_n |-> por_n); // R4

  AST_PWR_LOSS: assert property (@(posedge clk) disable iff (rst)
    !pg_ok_all |=> (!warm_n && !por_n && !full_n && !done)); // R10

  AST_DONE_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    done |-> full_n); // R8

  AST_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !done); // R9

  AST_TMO_RESETS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> (!warm_n && !por_n && !full_n)); // R9

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_seq_pkg::*;
#(
  parameter int N_RAILS      = 4,
  parameter int IO_RAIL      = 0,
  parameter int STAB_CYC     = 5000,
  parameter int REF_INIT     = 500,
  parameter int FULL_DLY     = 24,
  parameter int STRAP_SETUP  = 12,
  parameter int STRAP_HOLD   = 12,
  parameter int TMO_TICKS    = 60000,
  parameter bit AUTO_RESTART = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_clk,
  input  logic [N_RAILS-1:0] rail_good,
  input  logic               stat_in,
  input  logic               strap_endian_in,
  input  logic [12:0]        strap_boot_in,
  input  logic [1:0]         strap_pcie_mode_in,
  input  logic               strap_pcie_en_in,
  input  logic               strap_pa_sel_in,
  output logic               warm_rst_n,
  output logic               por_rst_n,
  output logic               full_rst_n,
  output logic               strap_oe,
  output logic               strap_endian,
  output logic [12:0]        strap_boot,
  output logic [1:0]         strap_pcie_mode,
  output logic               strap_pcie_en,
  output logic               strap_pa_sel,
  output logic               seq_done,
  output logic               seq_timeout
);

  localparam int SYNC_W = N_RAILS + 1;

  logic [SYNC_W-1:0] sync_q;
  logic [N_RAILS-1:0] rail_s;
  logic stat_s, pg_ok_all, io_ok, ref_tick, track, drive;
  strap_t strap_in, strap_q;

  por_sync #(.W(SYNC_W)) u_in_sync (
    .clk (clk),
    .rst (rst),
    .d   ({stat_in, rail_good}),
    .q   (sync_q)
  );

  assign rail_s    = sync_q[N_RAILS-1:0];
  assign stat_s    = sync_q[N_RAILS];
  assign pg_ok_all = &rail_s;
  assign io_ok     = rail_s[IO_RAIL];

  por_ref_tick u_tick (
    .clk    (clk),
    .rst    (rst),
    .ref_in (ref_clk),
    .tick   (ref_tick)
  );

  por_seq_fsm #(
    .STAB_CYC     (STAB_CYC),
    .REF_INIT     (REF_INIT),
    .FULL_DLY     (FULL_DLY),
    .STRAP_SETUP  (STRAP_SETUP),
    .STRAP_HOLD   (STRAP_HOLD),
    .TMO_TICKS    (TMO_TICKS),
    .AUTO_RESTART (AUTO_RESTART)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pg_ok_all   (pg_ok_all),
    .ref_tick    (ref_tick),
    .stat_ok     (stat_s),
    .warm_n      (warm_rst_n),
    .por_n       (por_rst_n),
    .full_n      (full_rst_n),
    .done        (seq_done),
    .timeout     (seq_timeout),
    .strap_track (track),
    .strap_drive (drive)
  );

  assign strap_in.endian    = strap_endian_in;
  assign strap_in.boot      = strap_boot_in;
  assign strap_in.pcie_mode = pcie_mode_e'(strap_pcie_mode_in);
  assign strap_in.pcie_en   = strap_pcie_en_in;
  assign strap_in.pa_sel    = strap_pa_sel_in;

  por_strap_drv u_strap (
    .clk      (clk),
    .rst      (rst),
    .io_ok    (io_ok),
    .track    (track),
    .drive    (drive),
    .strap_in (strap_in),
    .strap_q  (strap_q),
    .oe_q     (strap_oe)
  );

  assign strap_endian    = strap_q.endian;
  assign strap_boot      = strap_q.boot;
  assign strap_pcie_mode = strap_q.pcie_mode;
  assign strap_pcie_en   = strap_q.pcie_en;
  assign strap_pa_sel    = strap_q.pa_sel;

endmodule

// File: tb/tb_por_sequencer.sv
module tb_por_sequencer;

  localparam int NR    = 4;
  localparam int IOR   = 0;
  localparam int STAB  = 200;
  localparam int RINIT = 20;
  localparam int FDLY  = 24;
  localparam int SETUP = 12;
  localparam int HOLD  = 12;
  localparam int TMO   = 150;
  localparam int PORT  = (FDLY > SETUP) ? FDLY : SETUP;

  logic clk = 1'b0, ref_clk = 1'b0, rst = 1'b1;
  logic [NR-1:0] rail_good = '0;
  logic stat_in = 1'b0;
  logic in_endian = 1'b0, in_pcie_en = 1'b0, in_pa = 1'b0;
  logic [12:0] in_boot = '0;
  logic [1:0] in_mode = '0;
  logic warm_rst_n, por_rst_n, full_rst_n, strap_oe;
  logic strap_endian, strap_pcie_en, strap_pa_sel, seq_done, seq_timeout;
  logic [12:0] strap_boot;
  logic [1:0] strap_pcie_mode;

  por_sequencer #(
    .N_RAILS(NR), .IO_RAIL(IOR), .STAB_CYC(STAB), .REF_INIT(RINIT),
    .FULL_DLY(FDLY), .STRAP_SETUP(SETUP), .STRAP_HOLD(HOLD),
    .TMO_TICKS(TMO), .AUTO_RESTART(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .rail_good(rail_good), .stat_in(stat_in),
    .strap_endian_in(in_endian), .strap_boot_in(in_boot), .strap_pcie_mode_in(in_mode),
    .strap_pcie_en_in(in_pcie_en), .strap_pa_sel_in(in_pa),
    .warm_rst_n(warm_rst_n), .por_rst_n(por_rst_n), .full_rst_n(full_rst_n),
    .strap_oe(strap_oe), .strap_endian(strap_endian), .strap_boot(strap_boot),
    .strap_pcie_mode(strap_pcie_mode), .strap_pcie_en(strap_pcie_en),
    .strap_pa_sel(strap_pa_sel), .seq_done(seq_done), .seq_timeout(seq_timeout)
  );

  always #10 clk = ~clk;
  initial begin
    #7;
    forever #60 ref_clk = ~ref_clk;
  end

  int clk_cnt = 0;
  int refcnt = 0;
  always @(posedge clk) clk_cnt <= clk_cnt + 1;
  always @(posedge ref_clk) refcnt <= refcnt + 1;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [18:0] pack_bus(input logic oe, input logic e, input logic [12:0] b,
                                           input logic [1:0] m, input logic pe, input logic pa);
    return {oe, e, b, m, pe, pa};
  endfunction

  function automatic bit in_win(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  wire [18:0] out_bus = {strap_oe, strap_endian, strap_boot, strap_pcie_mode,
                         strap_pcie_en, strap_pa_sel};

  // event recorder: samples outputs between clock edges
  logic p_warm = 0, p_por = 0, p_full = 0, p_done = 0, p_tmo = 0;
  logic [18:0] p_bus = '0;
  bit hold_watch = 0;
  int n_warm = 0, n_por = 0, n_full = 0, n_hold = 0, n_done = 0, n_tmo = 0;
  int w_clk, w_ref, p_ref, f_ref, f_setup, lastchg_ref = 0, h_n, h_clk, d_clk, t_clk, t_ref;
  logic p_warm_at, f_por_at, d_oe, d_full, t_warm;
  logic [18:0] f_bus, h_bus;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_bus != p_bus) begin
        if (hold_watch) begin
          h_n = refcnt - f_ref; h_bus = out_bus; h_clk = clk_cnt;
          hold_watch = 0; n_hold++;
        end
        lastchg_ref = refcnt;
      end
      if (warm_rst_n && !p_warm) begin w_clk = clk_cnt; w_ref = refcnt; n_warm++; end
      if (por_rst_n && !p_por) begin p_ref = refcnt; p_warm_at = warm_rst_n; n_por++; end
      if (full_rst_n && !p_full) begin
        f_ref = refcnt; f_por_at = por_rst_n; f_bus = out_bus;
        f_setup = refcnt - lastchg_ref; hold_watch = 1; n_full++;
      end
      if (seq_done && !p_done) begin d_clk = clk_cnt; d_oe = strap_oe; d_full = full_rst_n; n_done++; end
      if (seq_timeout && !p_tmo) begin t_clk = clk_cnt; t_ref = refcnt; t_warm = warm_rst_n; n_tmo++; end
    end
    p_warm = warm_rst_n; p_por = por_rst_n; p_full = full_rst_n;
    p_done = seq_done; p_tmo = seq_timeout; p_bus = out_bus;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rand_straps();
    in_endian  = 1'($urandom_range(0, 1));
    in_boot    = 13'($urandom_range(0, 8191));
    in_mode    = 2'($urandom_range(0, 2));
    in_pcie_en = 1'($urandom_range(0, 1));
    in_pa      = 1'($urandom_range(0, 1));
  endtask

  function automatic logic [18:0] exp_now();
    return pack_bus(1'b1, in_endian, in_boot, in_mode, in_pcie_en, in_pa);
  endfunction

  task automatic check_all_low(input string req);
    chk(!warm_rst_n && !por_rst_n && !full_rst_n, req, "resets low",
        {warm_rst_n, por_rst_n, full_rst_n}, 0);
    chk(!seq_done, req, "done low", seq_done, 0);
  endtask

  task automatic rails_up(output int t_good);
    int order[NR];
    for (int i = 0; i < NR; i++) order[i] = i;
    for (int i = NR - 1; i > 0; i--) begin
      int j = $urandom_range(0, i);
      int t = order[i];
      order[i] = order[j]; order[j] = t;
    end
    for (int i = 0; i < NR; i++) begin
      if (!rail_good[IOR]) begin
        chk(out_bus == '0, "R7", "straps before io good", out_bus, 0);
        check_all_low("R1");
      end
      rail_good[order[i]] = 1'b1;
      tick($urandom_range(4, 20));
      if (i < NR - 1) check_all_low("R1");
      if (rail_good[IOR] && i < NR - 1)
        chk(out_bus == exp_now(), "R7", "straps follow inputs", out_bus, exp_now());
    end
    t_good = clk_cnt;
  endtask

  task automatic run_seq(input bit drop, input bit early, input bit tmo);
    int t_good, k;
    logic [18:0] exp_bus;
    rand_straps();
    exp_bus = exp_now();
    stat_in = early;
    rails_up(t_good);
    t_good = t_good - 20;
    k = n_warm;
    wait (n_warm > k);
    chk(in_win(w_clk - t_good, STAB, STAB + 26), "R2", "stab cycles", w_clk - t_good, STAB);
    rand_straps();
    if (drop) begin
      int r = $urandom_range(0, NR - 1);
      k = n_por;
      wait (n_por > k);
      tick(1);
      rail_good[r] = 1'b0;
      tick(5);
      check_all_low("R10");
      rail_good[r] = 1'b1;
      rand_straps();
      exp_bus = exp_now();
      t_good = clk_cnt;
      k = n_warm;
      wait (n_warm > k);
      chk(in_win(w_clk - t_good, STAB, STAB + 6), "R2", "stab after drop", w_clk - t_good, STAB);
      rand_straps();
    end
    k = n_por;
    wait (n_por > k);
    chk(p_warm_at, "R3", "warm high at por rise", p_warm_at, 1);
    chk(in_win(p_ref - w_ref, RINIT, RINIT + 2), "R3", "ref edges warm->por", p_ref - w_ref, RINIT);
    k = n_full;
    wait (n_full > k);
    chk(f_por_at, "R4", "por high at full rise", f_por_at, 1);
    chk(in_win(f_ref - p_ref, PORT, PORT + 2), "R4", "ref edges por->full", f_ref - p_ref, PORT);
    chk(f_bus == exp_bus, "R5", "straps at full rise", f_bus, exp_bus);
    chk(f_setup >= SETUP, "R5", "strap setup edges", f_setup, SETUP);
    k = n_hold;
    wait (n_hold > k);
    chk(in_win(h_n, HOLD, HOLD + 2), "R6", "strap hold edges", h_n, HOLD);
    chk(h_bus == '0, "R6", "straps released", h_bus, 0);
    if (tmo) begin
      k = n_tmo;
      wait (n_tmo > k);
      chk(t_ref - f_ref >= HOLD + TMO, "R9", "timeout edges", t_ref - f_ref, HOLD + TMO);
      chk(!t_warm, "R9", "resets low at timeout", t_warm, 0);
      exp_bus = exp_now();
      k = n_warm;
      wait (n_warm > k);
      chk(in_win(w_clk - t_clk, STAB, STAB + 6), "R9", "restart stab", w_clk - t_clk, STAB);
      k = n_full;
      wait (n_full > k);
      chk(f_bus == exp_bus, "R9", "straps after restart", f_bus, exp_bus);
      k = n_hold;
      wait (n_hold > k);
    end
    k = n_done;
    if (!early) begin
      int t_stat;
      repeat ($urandom_range(1, 100)) @(posedge ref_clk);
      tick(1);
      chk(!seq_done, "R8", "no done before status", seq_done, 0);
      stat_in = 1'b1;
      t_stat = clk_cnt;
      wait (n_done > k);
      chk(in_win(d_clk - t_stat, 2, 5), "R8", "done latency", d_clk - t_stat, 2);
    end else begin
      wait (n_done > k);
      chk(!d_oe && d_full, "R11", "early status waits for release", {d_oe, d_full}, 1);
      chk(in_win(d_clk - h_clk, 1, 3), "R11", "done after release", d_clk - h_clk, 1);
    end
    tick(2);
    chk(!seq_timeout, "R9", "timeout clear after done", seq_timeout, 0);
    rail_good = '0;
    stat_in = 1'b0;
    tick(5);
    check_all_low("R1");
    chk(out_bus == '0, "R7", "straps off after power down", out_bus, 0);
    tick(10);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    check_all_low("R1");
    chk(out_bus == '0 && !seq_timeout, "R1", "reset straps and timeout", out_bus, 0);
    rst = 1'b0;
    tick(5);
    check_all_low("R1");
    run_seq(1'b0, 1'b0, 1'b0);
    run_seq(1'b1, 1'b0, 1'b0);
    run_seq(1'b0, 1'b1, 1'b0);
    run_seq(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++)
      run_seq(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", clk_cnt);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule